// File: doc/BRIEF.md
# Capture-Compare PWM Timer

A 16-bit up-counter with a programmable count source, a set of input-capture channels, two compare registers that drive one compare output pin, and a PWM mode that uses those two registers together. The count source is either the system clock divided by 2^n (n = 0..7) or an external clock input. The external clock is synchronized, and each of its rising edges advances the counter once. Each capture channel synchronizes its input and copies the counter into its own holding register when the chosen edge arrives.

Overflow, compare and capture events set sticky status bits. Software clears a status bit by writing 1 to it. A single interrupt line is the OR of the status bits that are enabled. Software reaches all of this through a flat register port: one write strobe, an address, write data, and read data that follows the address without a clock delay.

Register map (word addresses): 0 control, 1 counter, 2 compare A, 3 compare B, 4 edge select, 5 interrupt enable, 6 status, 8+i capture channel i. Control bits: [0] run, [1] external source, [4:2] prescale exponent n, [5] PWM mode, [7:6] compare-A action, [9:8] compare-B action. Status and enable bit layout: [0] overflow, [1] compare A, [2] compare B, [3+i] capture channel i.

Top module: `ccp_timer`

## Requirements
- R1: After reset every register reads 0, and both `cmp_out` and `irq` are 0.
- R2: With run=1 and the internal source selected, the counter advances once every 2^n clocks, starting from the write that set run. With run=0 the counter holds its value.
- R3: With the external source selected, the counter advances exactly once for each rising edge of `ext_clk`, provided each level is held for at least 2 clocks.
- R4: When the counter wraps from 0xFFFF to 0 it sets status bit 0 (overflow).
- R5: Edge select for channel i sits in bits [2i+1:2i]: 00 none, 01 rising, 10 falling, 11 both. On a selected edge the channel latches the counter value and sets status bit 3+i.
- R6: A capture register keeps its value when its input has an edge that is not selected, and whenever no edge occurs.
- R7: Outside PWM mode, a count match on compare A or B sets status bit 1 or 2. The match also applies that register's action: 01 drives `cmp_out` high, 10 drives it low, and 00 or 11 leaves it unchanged. If both match in the same tick, B wins.
- R8: In PWM mode the counter goes from the compare-A value back to 0, so the period is A+1 ticks. `cmp_out` is high while the count is below compare B.
- R9: `irq` is high exactly when some status bit is set whose enable bit is also set. It stays high until those bits are cleared or disabled.
- R10: Writing 1 to a status bit clears it. An event in the same cycle as the clear leaves the bit set.
- R11: A write to the counter address loads the counter, and the loaded value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_in | input | NCAP | Capture inputs, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for `reg_addr` |
| cmp_out | output | 1 | Compare / PWM output pin |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted prescaler phase or a wrong counter next-state shows up as a wrong count the first time the counter is read back after a timed run. In PWM mode the same fault is visible within one period, as a count above compare A or as a misplaced `cmp_out` edge. A status or enable fault changes `irq` one clock after the event or clear that exposes it. A capture fault shows up in the channel's register or status bit about three clocks after the input edge, because of the synchronizer.

// File: rtl/ccpt_pkg.sv
package ccpt_pkg;

    typedef enum logic [3:0] {
        A_CTRL = 4'd0,
        A_CNT  = 4'd1,
        A_CMPA = 4'd2,
        A_CMPB = 4'd3,
        A_ESEL = 4'd4,
        A_IEN  = 4'd5,
        A_STAT = 4'd6,
        A_CAP0 = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'b00,
        ACT_HIGH  = 2'b01,
        ACT_LOW   = 2'b10,
        ACT_KEEP3 = 2'b11
    } cmp_act_e;

    typedef struct packed {
        logic [1:0] act_b;
        logic [1:0] act_a;
        logic       pwm;
        logic [2:0] pexp;
        logic       ext_src;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ccp_prescaler.sv
module ccp_prescaler #(
    parameter int EXP_W = 3,
    localparam int DIV_W = 1 << EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_src,
    input  logic [EXP_W-1:0] pexp,
    input  logic             ext_clk,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             s1;
        logic             s2;
        logic             prev;
    } pre_t;

    pre_t st_d, st_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = (DIV_W'(1) << pexp) - DIV_W'(1);
        st_d      = st_q;
        st_d.s1   = ext_clk;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        st_d.div  = (run && !ext_src) ? st_q.div + DIV_W'(1) : '0;
        if (ext_src) tick = run && st_q.s2 && !st_q.prev;
        else         tick = run && ((st_q.div & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a divided tick never repeats on the next cycle when n > 0
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ext_src && pexp != '0) ##1 ($stable(pexp) && !ext_src) |-> !tick);

    // R3: one tick per synchronized rising edge, never two in a row
    a_r3_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ext_src) |=> (!tick || !ext_src));

endmodule

// File: rtl/ccp_capture.sv
module ccp_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic [1:0]   esel,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_val,
    output logic         hit
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         s1;
        logic         s2;
        logic         prev;
    } cap_t;

    cap_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        rise = st_q.s2 && !st_q.prev;
        fall = !st_q.s2 && st_q.prev;
        hit  = (esel[0] && rise) || (esel[1] && fall);
        st_d      = st_q;
        st_d.s1   = cap_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (hit) st_d.val = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val = st_q.val;

    // R5: a qualifying edge latches the count seen in that cycle
    a_r5_latch: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cap_val == $past(cnt)));

    // R6: without a qualifying edge the held value does not move
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_val));

endmodule

// File: rtl/ccp_cmp_out.sv
module ccp_cmp_out
    import ccpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmpa,
    input  logic [W-1:0] cmpb,
    input  logic         pwm,
    input  logic [1:0]   act_a,
    input  logic [1:0]   act_b,
    output logic         match_a,
    output logic         match_b,
    output logic         pin
);

    typedef struct packed {
        logic pin;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        match_a = tick && (cnt == cmpa);
        match_b = tick && (cnt == cmpb);
        st_d = st_q;
        if (!pwm) begin
            if (match_a && act_a == ACT_HIGH) st_d.pin = 1'b1;
            if (match_a && act_a == ACT_LOW)  st_d.pin = 1'b0;
            if (match_b && act_b == ACT_HIGH) st_d.pin = 1'b1;
            if (match_b && act_b == ACT_LOW)  st_d.pin = 1'b0;
        end
        pin = pwm ? (cnt < cmpb) : st_q.pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a compare-B match with the drive-low action leaves the pin low
    a_r7_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && match_b && act_b == ACT_LOW) |=> (pwm || !pin));

    // R7: a compare-A match with the drive-high action and no B override
    a_r7_a_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && match_a && act_a == ACT_HIGH && !match_b) |=> (pwm || pin));

endmodule

// File: rtl/ccp_timer.sv
module ccp_timer
    import ccpt_pkg::*;
#(
    parameter int NCAP  = 3,
    parameter int W     = 16,
    localparam int SW   = 3 + NCAP,
    localparam int EXPW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_clk,
    input  logic [NCAP-1:0] cap_in,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [W-1:0]    reg_wdata,
    output logic [W-1:0]    reg_rdata,
    output logic            cmp_out,
    output logic            irq
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [W-1:0]      cnt;
        logic [W-1:0]      cmpa;
        logic [W-1:0]      cmpb;
        logic [2*NCAP-1:0] esel;
        logic [SW-1:0]     ien;
        logic [SW-1:0]     stat;
    } regs_t;

    regs_t st_d, st_q;

    logic            tick;
    logic            match_a, match_b;
    logic            ovf_ev, pwm_wrap, cnt_load;
    logic [NCAP-1:0] cap_hit;
    logic [W-1:0]    cap_vals [NCAP];
    logic [SW-1:0]   ev, clr;

    ccp_prescaler #(.EXP_W(EXPW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctrl.run),
        .ext_src (st_q.ctrl.ext_src),
        .pexp    (st_q.ctrl.pexp),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        ccp_capture #(.W(W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_in  (cap_in[g]),
            .esel    (st_q.esel[2*g +: 2]),
            .cnt     (st_q.cnt),
            .cap_val (cap_vals[g]),
            .hit     (cap_hit[g])
        );
    end

    ccp_cmp_out #(.W(W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt     (st_q.cnt),
        .cmpa    (st_q.cmpa),
        .cmpb    (st_q.cmpb),
        .pwm     (st_q.ctrl.pwm),
        .act_a   (st_q.ctrl.act_a),
        .act_b   (st_q.ctrl.act_b),
        .match_a (match_a),
        .match_b (match_b),
        .pin     (cmp_out)
    );

    always_comb begin
        st_d     = st_q;
        cnt_load = reg_wr && (reg_addr == A_CNT);
        pwm_wrap = st_q.ctrl.pwm && (st_q.cnt == st_q.cmpa);
        ovf_ev   = tick && !cnt_load && !pwm_wrap && (st_q.cnt == '1);

        if (cnt_load)      st_d.cnt = reg_wdata;
        else if (tick)     st_d.cnt = pwm_wrap ? '0 : st_q.cnt + W'(1);

        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                A_CMPA: st_d.cmpa = reg_wdata;
                A_CMPB: st_d.cmpb = reg_wdata;
                A_ESEL: st_d.esel = reg_wdata[2*NCAP-1:0];
                A_IEN:  st_d.ien  = reg_wdata[SW-1:0];
                default: ;
            endcase
        end

        ev  = {cap_hit, match_b, match_a, ovf_ev};
        clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[SW-1:0] : '0;
        st_d.stat = (st_q.stat & ~clr) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata = W'(st_q.ctrl);
            A_CNT:  reg_rdata = st_q.cnt;
            A_CMPA: reg_rdata = st_q.cmpa;
            A_CMPB: reg_rdata = st_q.cmpb;
            A_ESEL: reg_rdata = W'(st_q.esel);
            A_IEN:  reg_rdata = W'(st_q.ien);
            A_STAT: reg_rdata = W'(st_q.stat);
            default: ;
        endcase
        for (int i = 0; i < NCAP; i++) begin
            if (reg_addr == 4'(8 + i)) reg_rdata = cap_vals[i];
        end
    end

    assign irq = |(st_q.stat & st_q.ien);

    // R4: a wrap of the full count sets the overflow flag
    a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == '1 && !cnt_load && !pwm_wrap) |=> st_q.stat[0]);

    // R10: an event always survives a same-cycle clear
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((st_q.stat & $past(ev)) == $past(ev)));

    // R9: the line holds until status or enables are written
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && (reg_addr == A_STAT || reg_addr == A_IEN))) |=> irq);

    // R8: in PWM mode the count never leaves 0..A once inside it
    a_r8_pwm_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.pwm && st_q.cnt <= st_q.cmpa && !reg_wr) |=> (st_q.cnt <= st_q.cmpa));

endmodule

// File: tb/ccp_timer_tb_top.sv
module ccp_timer_tb_top;

    localparam int NCAP = 3;
    localparam int W    = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext_clk = 1'b0;
    logic [NCAP-1:0] cap_in = '0;
    logic            reg_wr = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [W-1:0]    reg_wdata = '0;
    logic [W-1:0]    reg_rdata;
    logic            cmp_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ccp_timer #(.NCAP(NCAP), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cap_in(cap_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_out(cmp_out), .irq(irq)
    );

    localparam logic [3:0] CTRL = 0, CNT = 1, CMPA = 2, CMPB = 3,
                           ESEL = 4, IEN = 5, STAT = 6, CAP0 = 8;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] ctrl_word(bit run, bit ext, int n, bit pwm, int aa, int ab);
        return W'(run) | (W'(ext) << 1) | (W'(n) << 2) | (W'(pwm) << 5)
             | (W'(aa) << 6) | (W'(ab) << 8);
    endfunction

    function automatic logic [W-1:0] exp_count(logic [W-1:0] start, int edges, int n);
        return start + W'(edges >> n);
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [W-1:0] v, start, exp_cap [NCAP];
        logic [2*NCAP-1:0] esel_m;
        void'($urandom(32'd4242));
        for (int i = 0; i < NCAP; i++) exp_cap[i] = '0;
        esel_m = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset values
        for (int a = 0; a < 8 + NCAP; a++) begin
            rd(4'(a), v); chk("R1 register reset", v, '0);
        end
        chk("R1 cmp_out reset", W'(cmp_out), '0);
        chk("R1 irq reset", W'(irq), '0);

        wr(CMPA, 16'h7777); wr(CMPB, 16'h7777);

        // R11: counter load, R2: prescaled counting, random exponents
        for (int it = 0; it < 8; it++) begin
            int n, l;
            n = $urandom % 4; l = $urandom % 40;
            start = 16'($urandom % 16'h7000);
            wr(CNT, start);
            rd(CNT, v); chk("R11 counter load", v, start);
            wr(CTRL, ctrl_word(1, 0, n, 0, 0, 0));
            idle(l);
            wr(CTRL, '0);
            rd(CNT, v); chk("R2 prescaled count", v, exp_count(start, l + 1, n));
            idle(6);
            rd(CNT, v); chk("R2 hold while stopped", v, exp_count(start, l + 1, n));
        end

        // R3: external clock counting
        for (int it = 0; it < 3; it++) begin
            int p;
            p = 1 + $urandom % 6;
            wr(CNT, 16'h0100);
            wr(CTRL, ctrl_word(1, 1, 5, 0, 0, 0));
            idle(4);
            for (int k = 0; k < p; k++) begin
                ext_clk = 1'b1; idle(3);
                ext_clk = 1'b0; idle(3);
            end
            idle(3);
            wr(CTRL, '0);
            rd(CNT, v); chk("R3 external edges", v, 16'h0100 + W'(p));
        end

        // R4 and R9: overflow with interrupt enabled
        wr(STAT, 16'hFFFF);
        wr(IEN, 16'h003F);
        wr(CNT, 16'hFFFE);
        wr(CTRL, ctrl_word(1, 0, 0, 0, 0, 0));
        idle(1);
        wr(CTRL, '0);
        rd(CNT, v);  chk("R4 wrapped count", v, 16'h0000);
        rd(STAT, v); chk("R4 overflow flag", v, 16'h0001);
        chk("R9 irq on enabled overflow", W'(irq), 1);
        idle(4);
        chk("R9 irq held until cleared", W'(irq), 1);
        wr(STAT, 16'h0001);
        rd(STAT, v); chk("R10 write-one clears", v, 16'h0000);
        chk("R9 irq drops after clear", W'(irq), 0);

        // R9: masked source does not raise irq
        wr(IEN, 16'h0000);
        wr(CNT, 16'hFFFF);
        wr(CTRL, ctrl_word(1, 0, 0, 0, 0, 0));
        wr(CTRL, '0);
        rd(STAT, v); chk("R4 second overflow", v, 16'h0001);
        chk("R9 masked irq low", W'(irq), 0);
        wr(IEN, 16'h0001);
        chk("R9 irq after enable", W'(irq), 1);
        wr(STAT, 16'hFFFF);

        // R7: compare actions
        wr(CMPA, 16'd5); wr(CMPB, 16'd8);
        wr(CNT, 16'd0);
        wr(CTRL, ctrl_word(1, 0, 0, 0, 1, 2));
        idle(5);
        wr(CTRL, '0);
        rd(CNT, v);  chk("R7 count at A", v, 16'd6);
        chk("R7 A drives high", W'(cmp_out), 1);
        rd(STAT, v); chk("R7 A flag", v, 16'h0002);
        wr(CTRL, ctrl_word(1, 0, 0, 0, 1, 2));
        idle(2);
        wr(CTRL, '0);
        chk("R7 B drives low", W'(cmp_out), 0);
        rd(STAT, v); chk("R7 A and B flags", v, 16'h0006);
        wr(STAT, 16'hFFFF);
        // R7: simultaneous match, B wins
        wr(CMPA, 16'd3); wr(CMPB, 16'd3); wr(CNT, 16'd3);
        wr(CTRL, ctrl_word(1, 0, 0, 0, 1, 2));
        wr(CTRL, '0);
        chk("R7 B wins on tie", W'(cmp_out), 0);
        wr(STAT, 16'hFFFF);

        // R8: PWM
        for (int it = 0; it < 3; it++) begin
            int a, b;
            logic [W-1:0] e;
            a = 3 + $urandom % 18; b = $urandom % (a + 2);
            wr(CMPA, W'(a)); wr(CMPB, W'(b)); wr(CNT, '0);
            wr(CTRL, ctrl_word(1, 0, 0, 1, 0, 0));
            e = '0;
            for (int c = 0; c < 45; c++) begin
                rd(CNT, v); chk("R8 PWM count", v, e);
                chk("R8 PWM output", W'(cmp_out), W'(e < W'(b)));
                idle(1);
                e = (e == W'(a)) ? '0 : e + 1'b1;
            end
            wr(CTRL, '0);
            wr(STAT, 16'hFFFF);
        end

        // R5, R6: capture with random edge selects
        for (int it = 0; it < 14; it++) begin
            int ch, sel;
            bit rising, hit;
            ch = $urandom % NCAP; sel = $urandom % 4;
            esel_m[2*ch +: 2] = 2'(sel);
            wr(ESEL, W'(esel_m));
            start = 16'($urandom);
            wr(CNT, start);
            wr(STAT, 16'hFFFF);
            cap_in[ch] = ~cap_in[ch];
            rising = cap_in[ch];
            idle(5);
            hit = (sel[0] && rising) || (sel[1] && !rising);
            if (hit) exp_cap[ch] = start;
            for (int k = 0; k < NCAP; k++) begin
                rd(CAP0 + 4'(k), v);
                chk(hit ? "R5 captured value" : "R6 value held", v, exp_cap[k]);
            end
            rd(STAT, v); chk("R5 capture flag", v, hit ? (W'(1) << (3 + ch)) : '0);
        end

        // R10: capture event and clear in the same cycle
        esel_m[1:0] = 2'b11;
        wr(ESEL, W'(esel_m));
        wr(CNT, 16'hABCD);
        wr(STAT, 16'hFFFF);
        cap_in[0] = ~cap_in[0];
        idle(2);
        wr(STAT, 16'hFFFF);
        rd(STAT, v); chk("R10 event beats clear", v, 16'h0008);
        rd(CAP0, v); chk("R5 capture on both edges", v, 16'hABCD);
        wr(STAT, 16'hFFFF);
        rd(STAT, v); chk("R10 later clear", v, 16'h0000);

        done = 1;
        report();
    end

endmodule